// File: doc/BRIEF.md
# Stoppable Serial Clock Output Driver

This block drives the serial clock pin of a smart card channel from an internal clock that a baud generator supplies. In ordinary operation the pin copies that internal clock, or sits low when the clock is disabled. When the level-fixing mode is on, software can stop the clock or restart it with a single register write. It can also park the pin high or low.

In the level-fixing mode, a write never takes effect at an arbitrary moment. Each change waits for an edge of the internal clock that leaves the pin in the requested direction. A stop lets the current high phase finish before the pin parks low. A start waits for the next rising edge, so the first pulse has full width. As a result, no high or low phase on the pin is ever shorter than half an internal clock period.

The internal clock arrives as a level that is synchronous to the system clock. The pin is registered and lags that level by one system clock cycle.

Top module: `sckfix_clk_out`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `sck_o` is 0 and the driver rests in its parked-low state.
- R2: With `fix_mode_i`=0 and `run_en_i`=1, `sck_o` equals the value `baud_clk_i` had at the previous rising edge of `clk`.
- R3: With `fix_mode_i`=0, `sel_level_i` has no effect. When `run_en_i`=0, `sck_o` is 0 one cycle later at any clock phase, even if this cuts a high phase short.
- R4: With `fix_mode_i`=1, `sel_level_i`=0 and `run_en_i`=0 (stop), a high phase in progress continues until `baud_clk_i` falls. `sck_o` then holds at 0.
- R5: With `fix_mode_i`=1, `sel_level_i`=0 and `run_en_i`=1 (start) while parked low, `sck_o` stays 0 until the first low-to-high change of `baud_clk_i` after the write. From then on it follows the clock as in R2.
- R6: With `fix_mode_i`=1 and `sel_level_i`=1 (park high, `run_en_i` ignored), a driver parked low waits for a rising edge of `baud_clk_i` before driving 1. Once high, `sck_o` holds at 1.
- R7: When a write leaves the parked-high state in `fix_mode_i`=1, `sck_o` stays 1 until `baud_clk_i` next falls. It then follows the clock or parks low, as the write selects.
- R8: With `fix_mode_i`=1, every rise of `sck_o` comes one cycle after a rise of `baud_clk_i`, and every fall comes one cycle after a fall. No complete high or low phase is shorter than a half period of `baud_clk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_clk_i | input | 1 | Internal serial clock level from the baud generator |
| fix_mode_i | input | 1 | Enables the level-fixing behaviour |
| sel_level_i | input | 1 | In level-fixing mode, 1 parks the pin high |
| run_en_i | input | 1 | Clock enable: 1 runs the clock, 0 stops it low |
| sck_o | output | 1 | Serial clock pin level |

## Verification
A wrong state in the parking controller shows up at the pin within one internal clock half period. The pin either follows the clock when it should hold, holds when it should follow, or changes one cycle after a system clock edge where the internal clock had no matching transition. A mis-tracked edge register shows up as a start or release that is one half period early or late, which shortens or stretches the first pulse. The bench watches every phase width in level-fixing mode, and it checks the exact cycle of each start, stop, park and release against the position of the internal clock when the write was made.

// File: rtl/sckfix_pkg.sv
package sckfix_pkg;

    typedef enum logic [1:0] {
        SCK_HOLD_LO = 2'd0,
        SCK_RUN     = 2'd1,
        SCK_HOLD_HI = 2'd2
    } sck_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } baud_edge_t;

    function automatic sck_state_e target_state(input logic fix_mode,
                                                input logic sel_level,
                                                input logic run_en);
        if (fix_mode && sel_level) return SCK_HOLD_HI;
        if (run_en)                return SCK_RUN;
        return SCK_HOLD_LO;
    endfunction

    function automatic logic level_of(input sck_state_e st, input logic clk_level);
        case (st)
            SCK_RUN:     return clk_level;
            SCK_HOLD_HI: return 1'b1;
            default:     return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/sckfix_edge_det.sv
module sckfix_edge_det
    import sckfix_pkg::*;
#(
    parameter bit PREV_RESET = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       level_i,
    output baud_edge_t edge_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= PREV_RESET;
        else     prev_q <= level_i;
    end

    always_comb begin
        edge_o.level = level_i;
        edge_o.rise  = level_i & ~prev_q;
        edge_o.fall  = ~level_i & prev_q;
    end
endmodule

// File: rtl/sckfix_ctrl.sv
module sckfix_ctrl
    import sckfix_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  baud_edge_t edge_i,
    input  logic       fix_mode_i,
    input  logic       sel_level_i,
    input  logic       run_en_i,
    output sck_state_e next_o
);
    sck_state_e state_q;
    sck_state_e want;

    always_comb begin
        want   = target_state(fix_mode_i, sel_level_i, run_en_i);
        next_o = state_q;
        if (!fix_mode_i) begin
            next_o = want;
        end else if (want != state_q) begin
            case (state_q)
                SCK_RUN: begin
                    if (want == SCK_HOLD_LO && !edge_i.level) next_o = want;
                    if (want == SCK_HOLD_HI &&  edge_i.level) next_o = want;
                end
                SCK_HOLD_LO: if (edge_i.rise) next_o = want;
                SCK_HOLD_HI: if (edge_i.fall) next_o = want;
                default:     next_o = SCK_HOLD_LO;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SCK_HOLD_LO;
        else     state_q <= next_o;
    end
endmodule

// File: rtl/sckfix_drive.sv
module sckfix_drive
    import sckfix_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sck_state_e next_i,
    input  logic       level_i,
    output logic       pin_o
);
    always_ff @(posedge clk) begin
        if (rst) pin_o <= 1'b0;
        else     pin_o <= level_of(next_i, level_i);
    end
endmodule

// File: rtl/sckfix_clk_out.sv
module sckfix_clk_out
    import sckfix_pkg::*;
#(
    parameter bit PREV_RESET = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic baud_clk_i,
    input  logic fix_mode_i,
    input  logic sel_level_i,
    input  logic run_en_i,
    output logic sck_o
);
    baud_edge_t edge_w;
    sck_state_e next_w;

    sckfix_edge_det #(.PREV_RESET(PREV_RESET)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .level_i (baud_clk_i),
        .edge_o  (edge_w)
    );

    sckfix_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .edge_i      (edge_w),
        .fix_mode_i  (fix_mode_i),
        .sel_level_i (sel_level_i),
        .run_en_i    (run_en_i),
        .next_o      (next_w)
    );

    sckfix_drive u_drive (
        .clk     (clk),
        .rst     (rst),
        .next_i  (next_w),
        .level_i (edge_w.level),
        .pin_o   (sck_o)
    );
endmodule

// File: rtl/sckfix_clk_out_chk.sv
module sckfix_clk_out_chk (
    input logic clk,
    input logic rst,
    input logic baud_clk_i,
    input logic fix_mode_i,
    input logic sel_level_i,
    input logic run_en_i,
    input logic sck_o
);
    assert_plain_follow_R2: assert property (@(posedge clk) disable iff (rst)
        (!fix_mode_i && run_en_i) |=> (sck_o == $past(baud_clk_i)));

    assert_plain_stop_R3: assert property (@(posedge clk) disable iff (rst)
        (!fix_mode_i && !run_en_i) |=> !sck_o);

    assert_hold_low_R4: assert property (@(posedge clk) disable iff (rst)
        (fix_mode_i && !sel_level_i && !run_en_i && !sck_o &&
         $past(fix_mode_i && !sel_level_i && !run_en_i)) |=> !sck_o);

    assert_hold_high_R6: assert property (@(posedge clk) disable iff (rst)
        (fix_mode_i && sel_level_i && sck_o &&
         $past(fix_mode_i && sel_level_i)) |=> sck_o);

    assert_rise_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(sck_o) && $past(fix_mode_i)) |-> ($past(baud_clk_i) && !$past(baud_clk_i, 2)));

    assert_fall_on_edge_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(sck_o) && $past(fix_mode_i)) |-> (!$past(baud_clk_i) && $past(baud_clk_i, 2)));
endmodule

bind sckfix_clk_out sckfix_clk_out_chk u_chk (.*);

// File: tb/test_sckfix_clk_out.sv
module test_sckfix_clk_out;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic baud = 1'b0;
    logic fix = 1'b0;
    logic sel = 1'b0;
    logic run = 1'b0;
    logic sck;
    int   ph = 0;
    int   errors = 0;
    int   checks = 0;
    int   viol = 0;
    int   pulses = 0;
    bit   done = 1'b0;

    sckfix_clk_out i_sckfix_clk_out (
        .clk(clk), .rst(rst), .baud_clk_i(baud), .fix_mode_i(fix),
        .sel_level_i(sel), .run_en_i(run), .sck_o(sck)
    );

    always #5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            if (rst) begin
                ph = 0; baud = 1'b0;
            end else begin
                ph = ph + 1;
                if (ph == HALF) begin ph = 0; baud = ~baud; end
            end
        end
    end

    // phase-width monitor for level-fixing mode (R8)
    initial begin
        int  runlen = 0;
        bit  valid = 1'b0;
        bit  allfix = 1'b0;
        logic last = 1'b0;
        forever begin
            @(posedge clk); #2;
            if (rst) begin
                runlen = 0; valid = 1'b0; last = sck;
            end else if (sck != last) begin
                if (valid && allfix && runlen < HALF) viol++;
                if (valid && allfix) pulses++;
                runlen = 1; valid = 1'b1; allfix = fix; last = sck;
            end else begin
                runlen++; allfix = allfix & fix;
            end
        end
    end

    task automatic chk(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: sck_o=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic wait_mid(input logic lvl);
        do begin @(negedge clk); #1; end while (!(baud == lvl && ph == 1));
    endtask

    task automatic t_reset();
        repeat (3) begin step(); chk(sck, 1'b0, "R1"); end
        @(negedge clk); #1; rst = 1'b0;
        step(); chk(sck, 1'b0, "R1");
    endtask

    task automatic t_plain_follow();
        @(negedge clk); #1; fix = 1'b0; sel = 1'b0; run = 1'b1;
        repeat (4 * HALF) begin step(); chk(sck, baud, "R2"); end
    endtask

    task automatic t_plain_stop();
        @(negedge clk); #1; sel = 1'b1;
        repeat (4 * HALF) begin step(); chk(sck, baud, "R3 sel ignored"); end
        wait_mid(1'b1); run = 1'b0;
        repeat (4 * HALF) begin step(); chk(sck, 1'b0, "R3"); end
        @(negedge clk); #1; sel = 1'b0; run = 1'b1;
        repeat (2 * HALF) step();
    endtask

    task automatic t_fix_stop();
        bit seen0 = 1'b0;
        @(negedge clk); #1; fix = 1'b1;
        repeat (4 * HALF) step();
        wait_mid(1'b1); run = 1'b0;
        repeat (8 * HALF) begin
            step();
            if (!seen0 && baud) chk(sck, 1'b1, "R4 high completes");
            else begin seen0 = 1'b1; chk(sck, 1'b0, "R4 held low"); end
        end
    endtask

    task automatic t_fix_start();
        bit seenlo = 1'b0;
        bit started = 1'b0;
        wait_mid(1'b1); run = 1'b1;
        repeat (8 * HALF) begin
            step();
            if (!baud) seenlo = 1'b1;
            if (seenlo && baud) started = 1'b1;
            chk(sck, started ? baud : 1'b0, "R5");
        end
    endtask

    task automatic t_park_high();
        bit seenlo = 1'b0;
        bit started = 1'b0;
        wait_mid(1'b0); run = 1'b0;
        repeat (6 * HALF) step();
        wait_mid(1'b1); sel = 1'b1;
        repeat (8 * HALF) begin
            step();
            if (!baud) seenlo = 1'b1;
            if (seenlo && baud) started = 1'b1;
            chk(sck, started, "R6");
        end
    endtask

    task automatic t_release_high();
        bit seenhi = 1'b0;
        bit released = 1'b0;
        wait_mid(1'b0); sel = 1'b0; run = 1'b1;
        repeat (8 * HALF) begin
            step();
            if (baud) seenhi = 1'b1;
            if (seenhi && !baud) released = 1'b1;
            chk(sck, released ? baud : 1'b1, "R7");
        end
    endtask

    task automatic t_widths();
        checks++;
        if (viol != 0 || pulses < 8) begin
            errors++;
            $display("FAIL R8: short phases=%0d pulses=%0d expected 0 and >=8", viol, pulses);
        end
    endtask

    initial begin
        int wd = 0;
        while (!done && wd < 20000) begin @(posedge clk); wd++; end
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_plain_follow();
        t_plain_stop();
        t_fix_stop();
        t_fix_start();
        t_park_high();
        t_release_high();
        t_widths();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule